// File: doc/BRIEF.md
# Sticky Alarm Register Bank with Per-Group Clear-on-Read

This block holds ten byte-wide sticky alarm registers and one configuration byte behind a simple byte register bus. Every alarm input bit sets its status bit on any clock where it is high. The bit then stays set until software clears it. The status registers form three groups: one single register, a handshake group of five registers, and a clock-status group of four registers.

Software can clear status bits in two ways. The first is clear-on-read, which a run-time configuration bit turns on or off for each group. The second is a write of one to individual bits. Neither kind of clear takes effect while the matching alarm input is still high.

The read data is a combinational function of the address. A read therefore returns the contents held before any clear it triggers. That clear takes effect at the clock edge that ends the read cycle.

Top module: `alarm_latch_bank`

## Requirements
- R1: A synchronous active-high reset sets the configuration byte to 0xFF and every status register to 0x00.
- R2: The configuration byte is at offset 0x4A, and all eight bits can be read and written. Bit 1 enables clear-on-read for the single register. Bit 2 enables it for the handshake group, and bit 3 for the clock-status group. Bits 0 and 7:4 are reserved but still hold whatever value is written.
- R3: A status bit becomes 1 at the clock edge where its alarm input is high, and it holds 1 until a qualified clear occurs.
- R4: A read of a status register whose group enable is 1 returns the current value. At the next edge, every bit of that register whose alarm input is low becomes 0.
- R5: A read of a status register whose group enable is 0 leaves every bit of that register unchanged.
- R6: Writing to a status register clears each bit that is written as 1 and leaves each bit written as 0 unchanged. This holds whatever the group enable is.
- R7: A clear from either a read or a write has no effect on a bit whose alarm input is high in the same cycle, and that bit stays 1.
- R8: A read from any unmapped offset returns 0x00. A write to an unmapped offset changes no register.
- R9: Each group's enable affects only that group's registers.
- R10: The status registers occupy these offsets: single at 0x40, handshake at 0x41 to 0x45, clock-status at 0x46 to 0x49. Alarm input bits [8k+7:8k] feed the register at offset 0x40+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| alarm_in | input | 80 | Alarm inputs, eight per status register |

## Verification
The assertions assume that the alarm inputs and the bus strobes are synchronous to clk and hold no unknown values after reset. They also assume that a read strobe stays high for exactly one cycle per intended access, because every extra cycle of strobe counts as another clearing read. The stimulus meets these assumptions in two ways. All inputs are driven on the falling clock edge. Each read or write is a single-cycle strobe, followed by at least one idle cycle before the next access. Alarm pulses are also one full cycle wide, so each pulse latches at exactly one rising edge.

// File: rtl/alarm_bank_pkg.sv
package alarm_bank_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        GRP_SINGLE = 2'd0,
        GRP_HAND   = 2'd1,
        GRP_CLOCK  = 2'd2
    } grp_e;

    // configuration byte layout, MSB first
    typedef struct packed {
        logic [3:0] spare_hi;     // bits 7:4
        logic       clock_cor;    // bit 3
        logic       hand_cor;     // bit 2
        logic       single_cor;   // bit 1
        logic       spare_lo;     // bit 0
    } cfg_t;

    localparam cfg_t CFG_RESET = cfg_t'(8'hFF);

    function automatic grp_e group_of(input int idx, input int hand_regs);
        if (idx == 0)
            return GRP_SINGLE;
        else if (idx <= hand_regs)
            return GRP_HAND;
        else
            return GRP_CLOCK;
    endfunction

endpackage

// File: rtl/abk_cfg_reg.sv
module abk_cfg_reg
    import alarm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output cfg_t              cfg_q
);

    typedef struct packed {
        cfg_t cfg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en)
            st_d.cfg = cfg_t'(wdata);
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q.cfg <= CFG_RESET;
        else
            st_q <= st_d;
    end

    assign cfg_q = st_q.cfg;

    // configuration only changes on a write
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_q));

    // every written bit is retained, reserved ones included
    p_cfg_load_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cfg_q == cfg_t'($past(wdata))));

endmodule

// File: rtl/abk_status_byte.sv
module abk_status_byte
    import alarm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] alarm,
    input  logic              rd_hit,
    input  logic              cor_en,
    input  logic              wr_hit,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] bits_q
);

    typedef struct packed {
        logic [BYTE_W-1:0] bits;
    } state_t;

    state_t st_d, st_q;
    logic [BYTE_W-1:0] rd_clr, wr_clr, clr_req;

    always_comb begin
        rd_clr  = (rd_hit && cor_en) ? {BYTE_W{1'b1}} : '0;
        wr_clr  = wr_hit ? wdata : '0;
        clr_req = rd_clr | wr_clr;
        st_d    = st_q;
        // a clear is granted only where the alarm is gone; a live alarm re-sets
        st_d.bits = (st_q.bits & ~(clr_req & ~alarm)) | alarm;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q.bits <= '0;
        else
            st_q <= st_d;
    end

    assign bits_q = st_q.bits;

    p_sticky_set_r3: assert property (@(posedge clk) disable iff (rst)
        (|alarm) |=> ((bits_q & $past(alarm)) == $past(alarm)));

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!rd_hit && !wr_hit) |=> ((bits_q & $past(bits_q)) == $past(bits_q)));

    p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && cor_en && !wr_hit && (alarm == '0)) |=> (bits_q == '0));

    p_read_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && !cor_en && !wr_hit) |=> ((bits_q & $past(bits_q)) == $past(bits_q)));

    p_w1c_zero_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !rd_hit) |=>
            ((bits_q & $past(bits_q & ~wdata)) == $past(bits_q & ~wdata)));

    p_live_alarm_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_hit || wr_hit) |=> ((bits_q & $past(alarm)) == $past(alarm)));

endmodule

// File: rtl/abk_decode.sv
module abk_decode #(
    parameter int          AW        = 8,
    parameter int          NREG      = 10,
    parameter logic [AW-1:0] STAT_BASE = 8'h40,
    parameter logic [AW-1:0] CFG_OFFS  = 8'h4A
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   addr,
    input  logic            rd,
    input  logic            wr,
    output logic            cfg_sel,
    output logic            cfg_wr,
    output logic [NREG-1:0] stat_sel,
    output logic [NREG-1:0] stat_rd,
    output logic [NREG-1:0] stat_wr
);

    always_comb begin
        cfg_sel = (addr == CFG_OFFS);
        cfg_wr  = cfg_sel && wr;
        for (int i = 0; i < NREG; i++) begin
            stat_sel[i] = (addr == AW'(STAT_BASE + AW'(i)));
            stat_rd[i]  = stat_sel[i] && rd;
            stat_wr[i]  = stat_sel[i] && wr;
        end
    end

    // map must not overlap
    p_single_target_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cfg_sel, stat_sel}));

endmodule

// File: rtl/abk_rdmux.sv
module abk_rdmux
    import alarm_bank_pkg::*;
#(
    parameter int NREG = 10
) (
    input  cfg_t                        cfg,
    input  logic                        cfg_sel,
    input  logic [NREG-1:0]             stat_sel,
    input  logic [NREG-1:0][BYTE_W-1:0] stat_bytes,
    output logic [BYTE_W-1:0]           rdata
);

    always_comb begin
        rdata = '0;
        if (cfg_sel)
            rdata = cfg;
        for (int i = 0; i < NREG; i++) begin
            if (stat_sel[i])
                rdata = rdata | stat_bytes[i];
        end
    end

endmodule

// File: rtl/alarm_latch_bank.sv
module alarm_latch_bank
    import alarm_bank_pkg::*;
#(
    parameter int            HAND_REGS  = 5,
    parameter int            CLOCK_REGS = 4,
    parameter logic [7:0]    STAT_BASE  = 8'h40,
    parameter logic [7:0]    CFG_OFFS   = 8'h4A
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [7:0]                            reg_addr,
    input  logic                                  reg_wr,
    input  logic [7:0]                            reg_wdata,
    input  logic                                  reg_rd,
    output logic [7:0]                            reg_rdata,
    input  logic [(1+HAND_REGS+CLOCK_REGS)*8-1:0] alarm_in
);

    localparam int NREG = 1 + HAND_REGS + CLOCK_REGS;
    localparam int AW   = 8;

    cfg_t                        cfg_q;
    logic                        cfg_sel, cfg_wr;
    logic [NREG-1:0]             stat_sel, stat_rd, stat_wr, cor_en;
    logic [NREG-1:0][BYTE_W-1:0] stat_bytes;

    abk_decode #(
        .AW(AW), .NREG(NREG), .STAT_BASE(STAT_BASE), .CFG_OFFS(CFG_OFFS)
    ) u_decode (
        .clk(clk), .rst(rst), .addr(reg_addr), .rd(reg_rd), .wr(reg_wr),
        .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
        .stat_sel(stat_sel), .stat_rd(stat_rd), .stat_wr(stat_wr)
    );

    abk_cfg_reg u_cfg (
        .clk(clk), .rst(rst), .wr_en(cfg_wr), .wdata(reg_wdata), .cfg_q(cfg_q)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_stat
        localparam grp_e GRP = group_of(g, HAND_REGS);
        if (GRP == GRP_SINGLE) begin : g_single
            assign cor_en[g] = cfg_q.single_cor;
        end else if (GRP == GRP_HAND) begin : g_hand
            assign cor_en[g] = cfg_q.hand_cor;
        end else begin : g_clock
            assign cor_en[g] = cfg_q.clock_cor;
        end

        abk_status_byte u_byte (
            .clk(clk), .rst(rst),
            .alarm(alarm_in[g*BYTE_W +: BYTE_W]),
            .rd_hit(stat_rd[g]), .cor_en(cor_en[g]),
            .wr_hit(stat_wr[g]), .wdata(reg_wdata),
            .bits_q(stat_bytes[g])
        );
    end

    abk_rdmux #(.NREG(NREG)) u_rdmux (
        .cfg(cfg_q), .cfg_sel(cfg_sel), .stat_sel(stat_sel),
        .stat_bytes(stat_bytes), .rdata(reg_rdata)
    );

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !cfg_sel && (stat_sel == '0)) |-> (reg_rdata == 8'h00));

endmodule

// File: tb/alarm_latch_bank_bench.sv
module alarm_latch_bank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       reg_addr = '0;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_wdata = '0;
    logic             reg_rd = 1'b0;
    logic [7:0]       reg_rdata;
    logic [NREG*8-1:0] alarm_in = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    alarm_latch_bank u_alarm_latch_bank (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .alarm_in(alarm_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: samples a quarter period after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (reg_rd && sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (reg_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: addr 0x%02h actual 0x%02h expected 0x%02h",
                             it.tag, it.addr, reg_rdata, it.exp);
                end
            end
        end
    end

    task automatic rd_expect(input logic [7:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.addr = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        reg_addr = a;
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd   = 1'b0;
        reg_addr = 8'h00;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = 8'h00;
    endtask

    // one-cycle alarm pulse on register k
    task automatic pulse(input int k, input logic [7:0] pat);
        @(negedge clk);
        alarm_in[k*8 +: 8] = pat;
        @(negedge clk);
        alarm_in[k*8 +: 8] = 8'h00;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd_expect(8'h4A, 8'hFF, "R1 cfg reset");
        rd_expect(8'h40, 8'h00, "R1 single reset");
        rd_expect(8'h41, 8'h00, "R1 hand0 reset");
        rd_expect(8'h45, 8'h00, "R1 hand4 reset");
        rd_expect(8'h46, 8'h00, "R1 clock0 reset");
        rd_expect(8'h49, 8'h00, "R1 clock3 reset");

        // R3 / R10 latching and mapping, R4 default clear-on-read
        pulse(0, 8'h81);
        pulse(1, 8'h12);
        pulse(5, 8'h30);
        pulse(6, 8'h0F);
        pulse(9, 8'hC0);
        repeat (2) @(negedge clk);
        rd_expect(8'h40, 8'h81, "R10 R3 single latched");
        rd_expect(8'h41, 8'h12, "R10 R3 hand0 latched");
        rd_expect(8'h45, 8'h30, "R10 R3 hand4 latched");
        rd_expect(8'h46, 8'h0F, "R10 R3 clock0 latched");
        rd_expect(8'h49, 8'hC0, "R10 R3 clock3 latched");
        rd_expect(8'h40, 8'h00, "R4 single cleared by read");
        rd_expect(8'h41, 8'h00, "R4 hand0 cleared by read");
        rd_expect(8'h49, 8'h00, "R4 clock3 cleared by read");

        // R2 config readback incl. reserved bits
        wr_reg(8'h4A, 8'h00);
        rd_expect(8'h4A, 8'h00, "R2 cfg all zero");
        wr_reg(8'h4A, 8'hF1);
        rd_expect(8'h4A, 8'hF1, "R2 cfg readback");

        // R5 all groups off
        pulse(0, 8'h55);
        pulse(2, 8'hAA);
        pulse(7, 8'h3C);
        rd_expect(8'h40, 8'h55, "R5 single first read");
        rd_expect(8'h40, 8'h55, "R5 single kept");
        rd_expect(8'h42, 8'hAA, "R5 hand1 first read");
        rd_expect(8'h42, 8'hAA, "R5 hand1 kept");
        rd_expect(8'h47, 8'h3C, "R5 clock1 first read");
        rd_expect(8'h47, 8'h3C, "R5 clock1 kept");

        // R9 only handshake group off (bit2 = 0)
        wr_reg(8'h4A, 8'hFB);
        rd_expect(8'h40, 8'h55, "R9 single read");
        rd_expect(8'h40, 8'h00, "R9 single cleared");
        rd_expect(8'h42, 8'hAA, "R9 hand1 read");
        rd_expect(8'h42, 8'hAA, "R9 hand1 kept");
        rd_expect(8'h47, 8'h3C, "R9 clock1 read");
        rd_expect(8'h47, 8'h00, "R9 clock1 cleared");

        // R6 write-one-to-clear
        wr_reg(8'h42, 8'h00);
        rd_expect(8'h42, 8'hAA, "R6 write zero no effect");
        wr_reg(8'h42, 8'h0A);
        rd_expect(8'h42, 8'hA0, "R6 partial clear");
        wr_reg(8'h42, 8'hA0);
        rd_expect(8'h42, 8'h00, "R6 full clear");

        // R7 live alarm blocks clears
        wr_reg(8'h4A, 8'hFF);
        @(negedge clk);
        alarm_in[3*8 +: 8] = 8'h01;
        rd_expect(8'h43, 8'h01, "R7 live alarm read");
        rd_expect(8'h43, 8'h01, "R7 read clear blocked");
        wr_reg(8'h43, 8'h01);
        rd_expect(8'h43, 8'h01, "R7 write clear blocked");
        @(negedge clk);
        alarm_in[3*8 +: 8] = 8'h00;
        rd_expect(8'h43, 8'h01, "R7 alarm gone still set");
        rd_expect(8'h43, 8'h00, "R7 clear after alarm gone");

        // R8 unmapped offsets
        pulse(4, 8'h77);
        rd_expect(8'h00, 8'h00, "R8 offset 00");
        rd_expect(8'h3F, 8'h00, "R8 offset 3F");
        rd_expect(8'h4B, 8'h00, "R8 offset 4B");
        rd_expect(8'hFF, 8'h00, "R8 offset FF");
        wr_reg(8'h4B, 8'h00);
        wr_reg(8'h3F, 8'hFF);
        wr_reg(8'h4C, 8'hFF);
        rd_expect(8'h4A, 8'hFF, "R8 cfg untouched");
        rd_expect(8'h44, 8'h77, "R8 hand3 untouched");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        finish_run();
    end

endmodule